// File: doc/BRIEF.md
# Interrupt redirection table controller

This block turns eight level-sensitive interrupt inputs into memory write messages. Each input owns a two-word entry in a 32-word redirection table. The low word holds a 6-bit vector, a mask flag and some stored mode flags. The high word holds a destination address in packed form. Software reaches the table only indirectly: it writes an index to a select register, then reads or writes the data window. Software clears the pending state through an end-of-interrupt (EOI) register.

When an input rises and its entry is enabled, the block sets a pending bit. If that pending bit was clear before, the block queues one 32-bit message for that input. The message-write master port carries one message at a time with a valid/ready handshake. Inputs that fire while the port is busy wait in a per-input request set. The lowest input index is sent first.

Top module: `irq_redir_ctrl`

## Requirements
- R1: After reset, table word 0x10+2i reads 0x1A000|(i+2) for each input i. This sets mask bit 16, level bit 15, active-low bit 13 and vector i+2. Word 0x11+2i reads the packed default target 0xA0FF0000. The select register reads 0 and no message is valid.
- R2: Reading window index 0x01 returns the version word 0x00200001. The table size (32) is in bits 31:16.
- R3: The select register sits at 0x800 and reads back what was written to it. The data window sits at 0x810 and accesses table word `select`. With a select of 32 or more, the window reads 0 and ignores writes. Any other register address reads 0.
- R4: A rising input whose low word has bit 16 set sends no message. The same holds when its destination word is zero. Either case clears pending bit (vector & 7).
- R5: A rising input that is enabled sets pending bit (vector & 7). It sends exactly one message only if that bit was clear. The message data is the vector in big-endian byte order: bits 31:24 hold the vector and bits 23:0 are zero.
- R6: The message address for destination word d has upper 32 bits all ones. Bits 31:28 are 0xF, bits 27:20 are d[23:16], bits 19:12 are d[31:24] and bits 11:0 are zero.
- R7: A rise whose pending bit is already set sends nothing.
- R8: A falling input clears pending bit (vector & 7), so the next rise of that input sends again.
- R9: A write to the EOI register at 0x840 takes the data mod 64. It clears pending bit i for every input i whose vector equals that value.
- R10: Only one message is outstanding. `msg_valid`, `msg_addr` and `msg_data` hold steady until `msg_ready`. The cycle after a handshake has `msg_valid` low.
- R11: Requests that collect while the port is busy are sent in order of increasing input index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_in | input | 8 | Level interrupt inputs |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Message accepted by the fabric |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message data word, big-endian |

## Verification
The assertions assume three things about the inputs:
- `msg_ready` may be held low for any length of time.
- `irq_in` changes only between clock edges.
- Register writes are single-cycle strobes.

The stimulus drives every input a time unit after the rising edge and never drops a pending handshake. Because of that, the stability checks on the held message depend only on the block itself. Test scenarios that rely on pending-bit sharing first reprogram several vectors to the same value. This avoids touching inputs that share a pending bit in the middle of a sequence.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam logic [31:0] LOW_MASK    = 32'h0001_0000;
  localparam logic [31:0] LOW_LEVEL   = 32'h0000_8000;
  localparam logic [31:0] LOW_POL_LOW = 32'h0000_2000;
  localparam logic [31:0] LOW_LOWPRI  = 32'h0000_0100;
  localparam int          MASK_BIT    = 16;
  localparam int          VEC_W       = 6;

  // Reset value of an input's low word
  function automatic logic [31:0] default_low(input int idx, input int vec_base);
    return LOW_POL_LOW | LOW_LEVEL | LOW_MASK | 32'(idx + vec_base);
  endfunction

  // Compress a target address into the table's destination field
  function automatic logic [31:0] pack_dest(input logic [31:0] a);
    return ((a & 32'h0FF0_0000) >> 4) | ((a & 32'h000F_F000) << 12);
  endfunction

  // Expand a destination field into a full 64-bit target address
  function automatic logic [63:0] unpack_dest(input logic [31:0] d);
    logic [31:0] lo;
    lo = ((d << 4) & 32'h0FF0_0000) | ((d >> 12) & 32'h000F_F000) | 32'hF000_0000;
    return {32'hFFFF_FFFF, lo};
  endfunction

  // Little-endian value to big-endian wire order
  function automatic logic [31:0] to_big_endian(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/irt_table.sv
module irt_table #(
  parameter int          NUM_IN    = 8,
  parameter int          TBL_WORDS = 32,
  parameter int          SEL_W     = 8,
  parameter int          VEC_BASE  = 2,
  parameter logic [31:0] CPU_ADDR  = 32'hFFFA_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [SEL_W-1:0]       sel,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic [NUM_IN-1:0][5:0] vec_o,
  output logic [NUM_IN-1:0]      mask_o,
  output logic [NUM_IN-1:0][31:0] dest_o
);
  localparam int IDX_W    = $clog2(TBL_WORDS);
  localparam int LOW_BASE = 16;
  localparam logic [SEL_W:0]  SEL_LIM = (SEL_W+1)'(TBL_WORDS);
  localparam logic [SEL_W-1:0] VER_IDX = SEL_W'(1);
  localparam logic [31:0] VERSION = (32'(TBL_WORDS) << 16) | 32'd1;

  logic [31:0] mem [TBL_WORDS];
  logic        in_range;

  function automatic logic [31:0] init_word(input int k);
    if (k >= LOW_BASE && k < LOW_BASE + 2*NUM_IN) begin
      if (((k - LOW_BASE) % 2) == 0) return irt_pkg::default_low((k - LOW_BASE)/2, VEC_BASE);
      return irt_pkg::pack_dest(CPU_ADDR);
    end
    return '0;
  endfunction

  assign in_range = {1'b0, sel} < SEL_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TBL_WORDS; k++) mem[k] <= init_word(k);
    end else if (we && in_range) begin
      mem[sel[IDX_W-1:0]] <= wdata;
    end
  end

  always_comb begin
    if (sel == VER_IDX)  rdata = VERSION;
    else if (in_range)   rdata = mem[sel[IDX_W-1:0]];
    else                 rdata = '0;
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_fields
    assign vec_o[i]  = mem[LOW_BASE + 2*i][5:0];
    assign mask_o[i] = mem[LOW_BASE + 2*i][irt_pkg::MASK_BIT];
    assign dest_o[i] = mem[LOW_BASE + 2*i + 1];
  end
endmodule

// File: rtl/irt_pending.sv
module irt_pending #(
  parameter int NUM_IN = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_IN-1:0]       irq_in,
  input  logic [NUM_IN-1:0][5:0]  vec,
  input  logic [NUM_IN-1:0]       mask,
  input  logic [NUM_IN-1:0][31:0] dest,
  input  logic                    eoi_we,
  input  logic [5:0]              eoi_val,
  input  logic [NUM_IN-1:0]       grant,
  output logic [NUM_IN-1:0]       req
);
  localparam int PB_W = $clog2(NUM_IN);

  logic [NUM_IN-1:0] prev_q, pend_q, pend_d, req_q, req_d;

  always_comb begin
    pend_d = pend_q;
    req_d  = req_q & ~grant;
    // EOI acts first, matching by vector and clearing by input index
    for (int i = 0; i < NUM_IN; i++)
      if (eoi_we && vec[i] == eoi_val) pend_d[i] = 1'b0;
    // Input edges in index order
    for (int i = 0; i < NUM_IN; i++) begin
      if (irq_in[i] && !prev_q[i]) begin
        if (!mask[i] && dest[i] != '0) begin
          if (!pend_d[vec[i][PB_W-1:0]]) req_d[i] = 1'b1;
          pend_d[vec[i][PB_W-1:0]] = 1'b1;
        end else begin
          pend_d[vec[i][PB_W-1:0]] = 1'b0;
        end
      end else if (!irq_in[i] && prev_q[i]) begin
        pend_d[vec[i][PB_W-1:0]] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= irq_in;
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/irt_sender.sv
module irt_sender #(
  parameter int NUM_IN = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_IN-1:0]       req,
  input  logic [NUM_IN-1:0][5:0]  vec,
  input  logic [NUM_IN-1:0][31:0] dest,
  input  logic                    msg_ready,
  output logic [NUM_IN-1:0]       grant,
  output logic                    load,
  output logic                    msg_valid,
  output logic [63:0]             msg_addr,
  output logic [31:0]             msg_data
);
  logic [5:0]  sel_vec;
  logic [31:0] sel_dest;

  assign grant = msg_valid ? '0 : (req & (~req + NUM_IN'(1)));
  assign load  = |grant;

  always_comb begin
    sel_vec  = '0;
    sel_dest = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (grant[i]) begin
        sel_vec  = sel_vec | vec[i];
        sel_dest = sel_dest | dest[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= irt_pkg::unpack_dest(sel_dest);
      msg_data  <= irt_pkg::to_big_endian(32'(sel_vec));
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl #(
  parameter int          NUM_IN    = 8,
  parameter int          TBL_WORDS = 32,
  parameter int          SEL_W     = 8,
  parameter int          VEC_BASE  = 2,
  parameter logic [31:0] CPU_ADDR  = 32'hFFFA_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_IN-1:0] irq_in,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam logic [11:0] A_SEL = 12'h800;
  localparam logic [11:0] A_WIN = 12'h810;
  localparam logic [11:0] A_EOI = 12'h840;

  logic [SEL_W-1:0]        sel_q;
  logic [31:0]             win_rdata;
  logic [NUM_IN-1:0][5:0]  vec_w;
  logic [NUM_IN-1:0]       mask_w;
  logic [NUM_IN-1:0][31:0] dest_w;
  logic [NUM_IN-1:0]       req_w, grant_w;
  logic                    load_w;
  logic                    wr_sel, wr_win, wr_eoi;

  assign wr_sel = reg_we && reg_addr == A_SEL;
  assign wr_win = reg_we && reg_addr == A_WIN;
  assign wr_eoi = reg_we && reg_addr == A_EOI;

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= reg_wdata[SEL_W-1:0];
  end

  always_comb begin
    case (reg_addr)
      A_SEL:   reg_rdata = 32'(sel_q);
      A_WIN:   reg_rdata = win_rdata;
      default: reg_rdata = '0;
    endcase
  end

  irt_table #(.NUM_IN(NUM_IN), .TBL_WORDS(TBL_WORDS), .SEL_W(SEL_W),
              .VEC_BASE(VEC_BASE), .CPU_ADDR(CPU_ADDR)) u_table (
    .clk(clk), .rst_n(rst_n), .we(wr_win), .sel(sel_q), .wdata(reg_wdata),
    .rdata(win_rdata), .vec_o(vec_w), .mask_o(mask_w), .dest_o(dest_w));

  irt_pending #(.NUM_IN(NUM_IN)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .vec(vec_w), .mask(mask_w),
    .dest(dest_w), .eoi_we(wr_eoi), .eoi_val(reg_wdata[5:0]), .grant(grant_w),
    .req(req_w));

  irt_sender #(.NUM_IN(NUM_IN)) u_send (
    .clk(clk), .rst_n(rst_n), .req(req_w), .vec(vec_w), .dest(dest_w),
    .msg_ready(msg_ready), .grant(grant_w), .load(load_w),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data));
endmodule

// File: rtl/irt_checker.sv
module irt_checker #(
  parameter int NUM_IN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [63:0]       msg_addr,
  input logic [31:0]       msg_data,
  input logic [NUM_IN-1:0] grant,
  input logic [NUM_IN-1:0] req,
  input logic              load
);
  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
  // R10
  msg_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);
  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !load);
  // R6
  addr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr[63:28] == 36'hF_FFFF_FFFF && msg_addr[11:0] == 12'h000);
  // R5
  data_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[23:0] == 24'h0 && msg_data[31:30] == 2'b00);
  // R11
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R11
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ((grant - NUM_IN'(1)) & req) == '0);
endmodule

bind irq_redir_ctrl irt_checker #(.NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .grant(grant_w), .req(req_w),
  .load(load_w));

// File: tb/tb_irq_redir_ctrl.sv
`timescale 1ns/1ps
module tb_irq_redir_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_in = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int n_chk = 0, n_err = 0, msg_cnt = 0, cyc = 0;
  logic [63:0] log_addr [64];
  logic [31:0] log_data [64];

  always #10 clk = ~clk;

  irq_redir_ctrl dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (msg_cnt < 64) begin
        log_addr[msg_cnt] = msg_addr;
        log_data[msg_cnt] = msg_data;
      end
      msg_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1 reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1 reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic win_wr(input int idx, input logic [31:0] d);
    wr(12'h800, 32'(idx)); wr(12'h810, d);
  endtask

  task automatic win_rd(input int idx, output logic [31:0] d);
    wr(12'h800, 32'(idx)); rd(12'h810, d);
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(posedge clk); #1 irq_in = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Bench's own view of the address expansion
  function automatic logic [63:0] exp_addr(input logic [31:0] d);
    return {32'hFFFF_FFFF, 4'hF, d[23:16], d[31:24], 12'h000};
  endfunction

  function automatic logic [31:0] exp_data(input int v);
    return {2'b00, 6'(v), 24'h0};
  endfunction

  initial begin
    logic [31:0] d;
    logic [31:0] dsweep [4];
    int b;
    dsweep[0] = 32'hA0FF_0000; dsweep[1] = 32'h5C3A_9000;
    dsweep[2] = 32'h0001_0000; dsweep[3] = 32'hFFFF_FFFF;

    wait_cyc(3); #1 rst_n = 1'b1;

    // R1: reset contents
    @(negedge clk); check("R1 msg_valid", 64'(msg_valid), 64'd0);
    rd(12'h800, d); check("R1 select", 64'(d), 64'd0);
    for (int i = 0; i < 8; i++) begin
      win_rd(16 + 2*i, d); check("R1 low word", 64'(d), 64'(32'h1A000 + i + 2));
      win_rd(17 + 2*i, d); check("R1 dest word", 64'(d), 64'h0A0FF0000);
    end
    // R2: version
    win_rd(1, d); check("R2 version", 64'(d), 64'h00200001);

    // R4: masked inputs send nothing
    b = msg_cnt; set_irq(8'hFF); wait_cyc(8);
    check("R4 masked rise", 64'(msg_cnt - b), 64'd0);
    set_irq(8'h00); wait_cyc(2);

    // R5 / R6: each input alone, unmasked
    for (int i = 0; i < 8; i++) begin
      win_wr(16 + 2*i, 32'h0000A000 | 32'(i + 2));
      b = msg_cnt; set_irq(8'(1 << i)); wait_cyc(6);
      check("R5 one message", 64'(msg_cnt - b), 64'd1);
      check("R5 data", 64'(log_data[b]), 64'(exp_data(i + 2)));
      check("R6 default addr", log_addr[b], 64'hFFFF_FFFF_FFFA_0000);
      set_irq(8'h00); wait_cyc(2);
    end

    // R6: destination sweep on input 4
    for (int k = 0; k < 4; k++) begin
      win_wr(17 + 8, dsweep[k]);
      b = msg_cnt; set_irq(8'h10); wait_cyc(6);
      check("R6 addr sweep", log_addr[b], exp_addr(dsweep[k]));
      set_irq(8'h00); wait_cyc(2);
    end
    // R4: zero destination
    win_wr(25, 32'h0);
    b = msg_cnt; set_irq(8'h10); wait_cyc(6);
    check("R4 zero dest", 64'(msg_cnt - b), 64'd0);
    set_irq(8'h00); win_wr(25, 32'hA0FF_0000);

    // R8: fall then rise sends again
    b = msg_cnt;
    set_irq(8'h08); wait_cyc(4); set_irq(8'h00); wait_cyc(2); set_irq(8'h08); wait_cyc(6);
    check("R8 rerise", 64'(msg_cnt - b), 64'd2);
    set_irq(8'h00); wait_cyc(2);

    // R11 / R10: queue while port stalled
    @(posedge clk); #1 msg_ready = 1'b0;
    b = msg_cnt; set_irq(8'b0010_1010); wait_cyc(5);
    @(negedge clk);
    check("R10 valid held", 64'(msg_valid), 64'd1);
    check("R11 first is lowest", 64'(msg_data), 64'(exp_data(3)));
    wait_cyc(3); @(negedge clk);
    check("R10 still held", 64'(msg_valid), 64'd1);
    check("R10 data stable", 64'(msg_data), 64'(exp_data(3)));
    check("R10 no handshake", 64'(msg_cnt - b), 64'd0);
    @(posedge clk); #1 msg_ready = 1'b1;
    wait_cyc(10);
    check("R11 count", 64'(msg_cnt - b), 64'd3);
    check("R11 order 0", 64'(log_data[b]),   64'(exp_data(3)));
    check("R11 order 1", 64'(log_data[b+1]), 64'(exp_data(5)));
    check("R11 order 2", 64'(log_data[b+2]), 64'(exp_data(7)));
    set_irq(8'h00); wait_cyc(2);

    // R3: window and decode
    wr(12'h800, 32'h0000_0040); rd(12'h800, d); check("R3 select readback", 64'(d), 64'h40);
    wr(12'h810, 32'hDEAD_BEEF); rd(12'h810, d); check("R3 out of range read", 64'(d), 64'd0);
    win_rd(0, d); check("R3 no alias write", 64'(d), 64'd0);
    win_wr(0, 32'h1234_5678); win_rd(0, d); check("R3 word write", 64'(d), 64'h12345678);
    win_wr(1, 32'h0); win_rd(1, d); check("R2 version fixed", 64'(d), 64'h00200001);
    rd(12'h7F8, d); check("R3 unmapped", 64'(d), 64'd0);

    // R7 / R9 / R4: shared pending bit (vector 8 -> bit 0)
    win_wr(16, 32'h0000A008); win_wr(18, 32'h0000A008);
    win_wr(20, 32'h0000A008); win_wr(22, 32'h0000A008);
    win_wr(26, 32'h0001A008);
    b = msg_cnt; set_irq(8'h01); wait_cyc(6);
    check("R5 shared first", 64'(msg_cnt - b), 64'd1);
    set_irq(8'h03); wait_cyc(6);
    check("R7 already pending", 64'(msg_cnt - b), 64'd1);
    wr(12'h840, 32'd72); // 72 mod 64 = 8
    set_irq(8'h07); wait_cyc(6);
    check("R9 eoi clears", 64'(msg_cnt - b), 64'd2);
    set_irq(8'h27); wait_cyc(4); // masked input 5 clears bit 0
    set_irq(8'h2F); wait_cyc(6);
    check("R4 masked rise clears", 64'(msg_cnt - b), 64'd3);
    set_irq(8'h00); wait_cyc(4);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule